// File: doc/BRIEF.md
# Paged Host Window Controller

This controller sits between a host processor's command port and the memories of a small arithmetic coprocessor. Through it the host loads operand scalars into the register array, loads program words into the instruction memory, reads results back from the output RAM, starts a run and polls whether the run is still busy or has completed. Every host command carries only a 5-bit address. A 2-bit page register, written by its own command, supplies the high-order address bits. Together they form a 7-bit double-word slot index.

Each access moves one 64-bit double word. In the register array a slot holds two 32-bit scalars, and the write port takes the slot index directly. In the instruction memory a slot is one half of a 128-bit program row: the row index is the slot index shifted right by one, and the lowest slot bit selects the half. The output RAM is written only by the datapath. The controller only reads it, using the same paged slot index, which does not depend on any register-array address. Writes reach the memory ports in the cycle the command is accepted. Reads answer one cycle later.

Top module: `hwc_window_ctrl`

## Requirements
- R1: Out of reset the page is 0, busy and done are 0, no memory strobe, `exec_go` or `rsp_valid` is high, and `cmd_ready` is high.
- R2: Opcode 0 loads the page from `cmd_wdata[1:0]`, ignoring all higher data bits. The page keeps its value until the next opcode 0, and it first applies to the command after the one that loads it.
- R3: Opcode 1 raises `ra_we` in the accepting cycle, with `ra_waddr = {page, cmd_addr}` and `ra_wdata = cmd_wdata`.
- R4: Opcode 2 raises `im_we` in the accepting cycle, with slot `{page, cmd_addr}`, `im_waddr = slot >> 1`, `im_whalf = slot[0]` and `im_wdata = cmd_wdata`.
- R5: Opcode 3 raises `or_re` in the accepting cycle, with `or_raddr = {page, cmd_addr}`. In the next cycle `rsp_valid` is high and `rsp_data` carries `or_rdata`.
- R6: `cmd_ready` is low exactly in the cycle in which `rsp_valid` is high, so a held command is accepted one cycle later.
- R7: Opcode 4 while idle gives a one-cycle `exec_go` pulse in the next cycle, sets busy and clears done.
- R8: Opcode 4 while busy is ignored: `exec_go` stays low, and busy and done keep their values.
- R9: `exec_fin` while busy clears busy and sets done from the next cycle. While idle, it has no effect.
- R10: Opcode 5 returns, in the next cycle, `rsp_data` with bit 0 = busy and bit 1 = done and all other bits 0. A finish that arrives in the accepting cycle is included.
- R11: Opcodes 6 and 7 raise no strobe, produce no response and leave the page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | 5 | Low slot address bits |
| cmd_wdata | input | 64 | Write data, or page value |
| rsp_valid | output | 1 | Read or status response present |
| rsp_data | output | 64 | Response data |
| ra_we | output | 1 | Register-array write strobe |
| ra_waddr | output | 7 | Register-array double-word slot |
| ra_wdata | output | 64 | Register-array write data (two scalars) |
| im_we | output | 1 | Instruction-memory write strobe |
| im_waddr | output | 6 | Instruction-memory row |
| im_whalf | output | 1 | Half of the row being written |
| im_wdata | output | 64 | Instruction-memory write data |
| or_re | output | 1 | Output-RAM read strobe |
| or_raddr | output | 7 | Output-RAM double-word slot |
| or_rdata | input | 64 | Output-RAM read data, one cycle after `or_re` |
| exec_go | output | 1 | One-cycle run start pulse to the datapath |
| exec_fin | input | 1 | Run-finished pulse from the datapath |

## Verification
Two pairs of events can land in the same cycle. The first is a datapath finish and the acceptance of a status poll. The bench raises `exec_fin` in the very cycle the status command is accepted, then expects the response to show done set and busy clear. The second is a finish and a start command during a run. The start must be dropped, so the bench expects no `exec_go`, and a following poll must report done with busy clear.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  localparam int OP_W          = 3;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_DONE_BIT = 1;

  typedef enum logic [OP_W-1:0] {
    OP_PAGE  = 3'd0,
    OP_RAWR  = 3'd1,
    OP_IMWR  = 3'd2,
    OP_ORRD  = 3'd3,
    OP_START = 3'd4,
    OP_STAT  = 3'd5
  } hwc_op_e;

endpackage

// File: rtl/hwc_page_reg.sv
module hwc_page_reg #(
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] din,
  output logic [PAGE_W-1:0] page
);

  always_ff @(posedge clk) begin
    if (!rst_n)    page <= '0;
    else if (load) page <= din;
  end

  // R2: the page moves only after a page command
  p_page_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (page != $past(page)) |-> $past(load));

endmodule

// File: rtl/hwc_cmd_decode.sv
module hwc_cmd_decode
  import hwc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int PAGE_W = 2,
  localparam int SLOT_W = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [PAGE_W-1:0] page,
  output logic              page_ld,
  output logic              ra_we,
  output logic              im_we,
  output logic              or_re,
  output logic              start_req,
  output logic              stat_req,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-2:0] im_row,
  output logic              im_half
);

  function automatic logic [SLOT_W-1:0] make_slot(input logic [PAGE_W-1:0] pg,
                                                  input logic [ADDR_W-1:0] ad);
    return {pg, ad};
  endfunction

  function automatic logic [SLOT_W-2:0] row_of(input logic [SLOT_W-1:0] s);
    return s[SLOT_W-1:1];
  endfunction

  function automatic logic half_of(input logic [SLOT_W-1:0] s);
    return s[0];
  endfunction

  logic accept;
  assign accept  = cmd_valid && cmd_ready;
  assign slot    = make_slot(page, cmd_addr);
  assign im_row  = row_of(slot);
  assign im_half = half_of(slot);

  always_comb begin
    page_ld   = 1'b0;
    ra_we     = 1'b0;
    im_we     = 1'b0;
    or_re     = 1'b0;
    start_req = 1'b0;
    stat_req  = 1'b0;
    if (accept) begin
      case (hwc_op_e'(cmd_op))
        OP_PAGE:  page_ld   = 1'b1;
        OP_RAWR:  ra_we     = 1'b1;
        OP_IMWR:  im_we     = 1'b1;
        OP_ORRD:  or_re     = 1'b1;
        OP_START: start_req = 1'b1;
        OP_STAT:  stat_req  = 1'b1;
        default:  ;
      endcase
    end
  end

  // R11: at most one action per accepted command
  p_one_action_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({page_ld, ra_we, im_we, or_re, start_req, stat_req}));

endmodule

// File: rtl/hwc_run_ctl.sv
module hwc_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic exec_fin,
  output logic exec_go,
  output logic busy,
  output logic done
);

  logic fin_take, start_take;
  assign fin_take   = exec_fin && busy;
  assign start_take = start_req && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      exec_go <= 1'b0;
    end else begin
      exec_go <= start_take;
      if (fin_take) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (start_take) begin
        busy <= 1'b1;
        done <= 1'b0;
      end
    end
  end

  // R7: a go pulse only on the transition from idle to busy
  p_go_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |-> (busy && !$past(busy)));

  // R8: a start while busy never yields a go pulse
  p_start_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && busy) |=> !exec_go);

  // R9: a finish during a run ends it with done set
  p_fin_sets_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fin && busy) |=> (done && !busy));

endmodule

// File: rtl/hwc_rsp_path.sv
module hwc_rsp_path
  import hwc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_or,
  input  logic              rd_stat,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] or_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic pend_or, pend_stat;
  logic [DATA_W-1:0] stat_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_or   <= 1'b0;
      pend_stat <= 1'b0;
    end else begin
      pend_or   <= rd_or;
      pend_stat <= rd_stat;
    end
  end

  always_comb begin
    stat_word                = '0;
    stat_word[STAT_BUSY_BIT] = busy;
    stat_word[STAT_DONE_BIT] = done;
  end

  assign rsp_valid = pend_or || pend_stat;
  assign rsp_data  = pend_stat ? stat_word : or_rdata;

  // R5: every response follows an accepted read or status command
  p_rsp_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_or || rd_stat));

  // R6: the stall keeps responses from landing in two adjacent cycles
  p_rsp_spaced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/hwc_window_ctrl.sv
module hwc_window_ctrl
  import hwc_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int PAGE_W = 2,
  parameter int DATA_W = 64,
  localparam int SLOT_W = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              ra_we,
  output logic [SLOT_W-1:0] ra_waddr,
  output logic [DATA_W-1:0] ra_wdata,
  output logic              im_we,
  output logic [SLOT_W-2:0] im_waddr,
  output logic              im_whalf,
  output logic [DATA_W-1:0] im_wdata,
  output logic              or_re,
  output logic [SLOT_W-1:0] or_raddr,
  input  logic [DATA_W-1:0] or_rdata,
  output logic              exec_go,
  input  logic              exec_fin
);

  logic [PAGE_W-1:0] page;
  logic [SLOT_W-1:0] slot;
  logic              page_ld, start_req, stat_req;
  logic              busy, done;

  assign cmd_ready = !rsp_valid;

  hwc_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (page_ld),
    .din   (cmd_wdata[PAGE_W-1:0]),
    .page  (page)
  );

  hwc_cmd_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .page      (page),
    .page_ld   (page_ld),
    .ra_we     (ra_we),
    .im_we     (im_we),
    .or_re     (or_re),
    .start_req (start_req),
    .stat_req  (stat_req),
    .slot      (slot),
    .im_row    (im_waddr),
    .im_half   (im_whalf)
  );

  assign ra_waddr = slot;
  assign or_raddr = slot;
  assign ra_wdata = cmd_wdata;
  assign im_wdata = cmd_wdata;

  hwc_run_ctl u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .exec_fin  (exec_fin),
    .exec_go   (exec_go),
    .busy      (busy),
    .done      (done)
  );

  hwc_rsp_path #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_or     (or_re),
    .rd_stat   (stat_req),
    .busy      (busy),
    .done      (done),
    .or_rdata  (or_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // R3: register-array writes carry the page in the high slot bits
  p_ra_paged_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ra_we |-> (ra_waddr[SLOT_W-1:ADDR_W] == page));

endmodule

// File: tb/hwc_window_ctrl_tb.sv
`timescale 1ns/1ps
module hwc_window_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [4:0]  cmd_addr = '0;
  logic [63:0] cmd_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        ra_we;
  logic [6:0]  ra_waddr;
  logic [63:0] ra_wdata;
  logic        im_we;
  logic [5:0]  im_waddr;
  logic        im_whalf;
  logic [63:0] im_wdata;
  logic        or_re;
  logic [6:0]  or_raddr;
  logic [63:0] or_rdata = '0;
  logic        exec_go;
  logic        exec_fin = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hwc_window_ctrl u_dut (.*);

  function automatic logic [63:0] or_model(input logic [6:0] a);
    return {a, 8'h3C, 42'd0, a};
  endfunction

  always @(posedge clk) if (or_re) or_rdata <= or_model(or_raddr);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [4:0] ad, input logic [63:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = ad; cmd_wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_valid = 1'b0; exec_fin = 1'b0;
    #1;
  endtask

  task automatic stat_read(input string tag, input logic [1:0] exp);
    drive(3'd5, 5'd0, 64'd0);
    idle();
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " status"}, rsp_data, {62'd0, exp});
  endtask

  // op, addr, data, expected slot
  localparam int NV = 10;
  localparam logic [30:0] VEC [NV] = '{
    {3'd0, 5'd0,  16'h0002, 7'd0},
    {3'd1, 5'd5,  16'h1111, 7'd69},
    {3'd2, 5'd7,  16'h2222, 7'd71},
    {3'd0, 5'd9,  16'h0003, 7'd0},
    {3'd1, 5'd31, 16'h3333, 7'd127},
    {3'd2, 5'd0,  16'h4444, 7'd96},
    {3'd0, 5'd0,  16'h0000, 7'd0},
    {3'd1, 5'd1,  16'h5555, 7'd1},
    {3'd0, 5'd0,  16'hFFF7, 7'd0},
    {3'd2, 5'd2,  16'h6666, 7'd98}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state at the ports
    chk("R1 cmd_ready", 64'(cmd_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 strobes", 64'({ra_we, im_we, or_re, exec_go}), 64'd0);
    stat_read("R1", 2'b00);

    // R2 R3 R4: table walk of paged writes
    for (int i = 0; i < NV; i++) begin
      logic [2:0]  op;
      logic [4:0]  ad;
      logic [15:0] d;
      logic [6:0]  s;
      {op, ad, d, s} = VEC[i];
      drive(op, ad, {4{d}});
      if (op == 3'd0) begin
        chk("R2 page cmd no write", 64'({ra_we, im_we, or_re}), 64'd0);
      end else if (op == 3'd1) begin
        chk("R3 ra_we", 64'(ra_we), 64'd1);
        chk("R3 ra_waddr", 64'(ra_waddr), 64'(s));
        chk("R3 ra_wdata", ra_wdata, {4{d}});
      end else begin
        chk("R4 im_we", 64'(im_we), 64'd1);
        chk("R4 im_waddr", 64'(im_waddr), 64'(s >> 1));
        chk("R4 im_whalf", 64'(im_whalf), 64'(s[0]));
        chk("R4 im_wdata", im_wdata, {4{d}});
      end
    end

    // R5: output read on page 1
    drive(3'd0, 5'd0, 64'd1);
    drive(3'd3, 5'd9, 64'd0);
    chk("R5 or_re", 64'(or_re), 64'd1);
    chk("R5 or_raddr", 64'(or_raddr), 64'd41);
    idle();
    chk("R5 rsp_valid", 64'(rsp_valid), 64'd1);
    chk("R5 rsp_data", rsp_data, or_model(7'd41));
    chk("R6 ready low with rsp", 64'(cmd_ready), 64'd0);
    @(negedge clk); #1;
    chk("R6 ready back", 64'(cmd_ready), 64'd1);
    chk("R5 single rsp", 64'(rsp_valid), 64'd0);

    // R6: back-to-back reads stall
    drive(3'd3, 5'd3, 64'd0);
    drive(3'd3, 5'd4, 64'd0);
    chk("R6 stall ready", 64'(cmd_ready), 64'd0);
    chk("R6 stall no read", 64'(or_re), 64'd0);
    chk("R5 first data", rsp_data, or_model(7'd35));
    @(negedge clk); #1;
    chk("R6 held cmd taken", 64'({cmd_ready, or_re}), 64'd3);
    chk("R5 second addr", 64'(or_raddr), 64'd36);
    idle();
    chk("R5 second data", rsp_data, or_model(7'd36));

    // R9: finish while idle is ignored
    @(negedge clk); exec_fin = 1'b1;
    idle();
    stat_read("R9 idle fin", 2'b00);

    // R7: start from idle
    drive(3'd4, 5'd0, 64'd0);
    idle();
    chk("R7 exec_go", 64'(exec_go), 64'd1);
    @(negedge clk); #1;
    chk("R7 go one cycle", 64'(exec_go), 64'd0);
    stat_read("R7 busy", 2'b01);

    // R8: start while busy
    drive(3'd4, 5'd0, 64'd0);
    idle();
    chk("R8 no go", 64'(exec_go), 64'd0);
    stat_read("R8 unchanged", 2'b01);

    // R10: finish in the status acceptance cycle
    drive(3'd5, 5'd0, 64'd0);
    exec_fin = 1'b1;
    idle();
    chk("R10 rsp_valid", 64'(rsp_valid), 64'd1);
    chk("R10 fin included", rsp_data, 64'd2);

    // R7: restart clears done
    drive(3'd4, 5'd0, 64'd0);
    idle();
    chk("R7 restart go", 64'(exec_go), 64'd1);
    stat_read("R7 done cleared", 2'b01);

    // R8 R9: finish and start in one cycle while busy
    drive(3'd4, 5'd0, 64'd0);
    exec_fin = 1'b1;
    idle();
    chk("R8 start dropped on fin", 64'(exec_go), 64'd0);
    stat_read("R9 done", 2'b10);

    // R11: unused opcodes
    drive(3'd6, 5'd3, 64'd3);
    chk("R11 op6 no strobe", 64'({ra_we, im_we, or_re}), 64'd0);
    drive(3'd7, 5'd3, 64'd2);
    chk("R11 op7 no strobe", 64'({ra_we, im_we, or_re}), 64'd0);
    idle();
    chk("R11 no rsp", 64'(rsp_valid), 64'd0);
    chk("R11 no go", 64'(exec_go), 64'd0);
    drive(3'd1, 5'd3, 64'hABCD);
    chk("R11 page kept", 64'(ra_waddr), 64'd35);
    idle();
    stat_read("R11 status kept", 2'b10);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule